// File: doc/BRIEF.md
# Sixteen-Pin GPIO Port with Peripheral Function Select

This block drives one bank of sixteen pads. Each pin works either as a software-controlled general-purpose pin or as a pin owned by one of four peripheral channels. A per-pin function-enable bit decides which of the two applies. When the bit is set, a two-bit selector field for that pin picks the peripheral channel. In that case the pad's drive value and drive enable come from the chosen channel, and the pad input is passed back to that channel only.

In general-purpose mode, software sets the pin's drive direction, its output latch and its input gate. Direction and output data each have separate set and clear addresses. Software writes a mask of ones to these addresses, so it can change single bits without a read-modify-write. The pad input passes through a two-stage synchroniser. A read of the data register shows the output latch on output pins, and the synchronised pad level on input pins whose input gate is open.

The register interface is a single-cycle word-indexed port. A write takes effect on the clock edge where `wr_en` is high. `rdata` always shows the register selected by `addr`.

Top module: `gpio_fnmux_port`

## Requirements
- R1: After a synchronous active-low reset, the following are all zero: function enable, selector fields, direction, output latch and input gate. As a result, `pad_oe` and every `fn_in` bit read 0.
- R2: Register word indices are: 0 function enable, 1 selector, 2 data, 3 data-set, 4 data-clear, 5 direction-set, 6 direction-clear, 7 input gate. The selector register is 32 bits, and pin n uses bits 2n+1:2n. Selector, function-enable and input-gate reads return the last value written.
- R3: A pin with function enable 0 drives `pad_out` from its output latch and `pad_oe` from its direction bit, where 1 means output.
- R4: A pin with function enable 1 takes `pad_out` and `pad_oe` from the channel named by its selector field. `fn_in` (bit index pin*4+channel) carries `pad_in` on that channel and 0 on the other three. All `fn_in` bits of general-purpose pins are 0.
- R5: A write to data-set sets the latch bits given by ones in the mask. A write to data-clear clears them. Bits where the mask is zero keep their value.
- R6: A write to direction-set or direction-clear sets or clears direction bits by write-one mask. Reads at indices 5 and 6 return the current direction.
- R7: A data read of an output pin returns its output latch.
- R8: A data read of an input pin with its input gate set returns the pad level. A pad change first shows up after the second rising edge.
- R9: A data read of an input pin with its input gate clear returns 0, whatever the pad level.
- R10: A write to the data index replaces the whole output latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register word index |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| pad_in | input | 16 | Pad input levels |
| pad_out | output | 16 | Pad drive values |
| pad_oe | output | 16 | Pad drive enables |
| fn_out | input | 64 | Peripheral drive values, index pin*4+channel |
| fn_oe | input | 64 | Peripheral drive enables, index pin*4+channel |
| fn_in | output | 64 | Pad input routed to the owning channel |

## Verification
A corrupted latch, direction or selector bit shows up at the pads in the cycle right after the write that caused it. This is because `pad_out`, `pad_oe` and `fn_in` are combinational from the registers. A wrong synchroniser depth or a wrong input gate shows up only on data reads. The bench therefore reads one cycle early and one cycle on time after each pad change. Wrong channel selection is caught by giving every unselected channel the opposite drive value.

// File: rtl/gpio_fnmux_pkg.sv
// Package: register word indices shared by the port and its checker.
// Assumes a word-indexed register port of eight entries.
package gpio_fnmux_pkg;
    localparam int REG_IDX_W = 3;

    typedef enum logic [REG_IDX_W-1:0] {
        RA_FNEN   = 3'd0,
        RA_SEL    = 3'd1,
        RA_DATA   = 3'd2,
        RA_DSET   = 3'd3,
        RA_DCLR   = 3'd4,
        RA_DIRSET = 3'd5,
        RA_DIRCLR = 3'd6,
        RA_INEN   = 3'd7
    } reg_idx_e;
endpackage

// File: rtl/gpio_fnmux_regs.sv
// Register file: function enable, selector fields, output latch, direction
// and input gate, with write-one set/clear for latch and direction.
// Assumes NPINS*SELW <= BUS_W and that writes are single-cycle strobes.
module gpio_fnmux_regs
    import gpio_fnmux_pkg::*;
#(
    parameter int NPINS = 16,
    parameter int SELW  = 2,
    parameter int BUS_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [REG_IDX_W-1:0]  addr,
    input  logic [BUS_W-1:0]      wdata,
    output logic [NPINS-1:0]      fnen_q,
    output logic [NPINS*SELW-1:0] sel_q,
    output logic [NPINS-1:0]      dout_q,
    output logic [NPINS-1:0]      dir_q,
    output logic [NPINS-1:0]      inen_q
);
    localparam int SEL_BITS = NPINS * SELW;

    logic [NPINS-1:0] mask;
    assign mask = wdata[NPINS-1:0];

    // Update the addressed register on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fnen_q <= '0;
            sel_q  <= '0;
            dout_q <= '0;
            dir_q  <= '0;
            inen_q <= '0;
        end else if (wr_en) begin
            case (reg_idx_e'(addr))
                RA_FNEN:   fnen_q <= mask;
                RA_SEL:    sel_q  <= wdata[SEL_BITS-1:0];
                RA_DATA:   dout_q <= mask;
                RA_DSET:   dout_q <= dout_q | mask;
                RA_DCLR:   dout_q <= dout_q & ~mask;
                RA_DIRSET: dir_q  <= dir_q | mask;
                RA_DIRCLR: dir_q  <= dir_q & ~mask;
                RA_INEN:   inen_q <= mask;
                default:   ;
            endcase
        end
    end
endmodule

// File: rtl/gpio_fnmux_sync.sv
// Multi-stage synchroniser for the pad inputs.
// Assumes STAGES >= 1; output is the last stage.
module gpio_fnmux_sync #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    // Shift the pad levels through the stage chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_fnmux_pin.sv
// Per-pin routing: picks general-purpose or peripheral drive for one pad and
// returns the pad input only to the owning channel.
// Assumes a selector value >= NFUNC selects no channel (pad released).
module gpio_fnmux_pin #(
    parameter int NFUNC = 4,
    parameter int SELW  = 2
) (
    input  logic             fn_en,
    input  logic [SELW-1:0]  sel,
    input  logic             gpio_out,
    input  logic             gpio_oe,
    input  logic             pad_in,
    input  logic [NFUNC-1:0] ch_out,
    input  logic [NFUNC-1:0] ch_oe,
    output logic             pad_out,
    output logic             pad_oe,
    output logic [NFUNC-1:0] ch_in
);
    // Choose the drive source and steer the input back.
    always_comb begin
        pad_out = gpio_out;
        pad_oe  = gpio_oe;
        ch_in   = '0;
        if (fn_en) begin
            pad_out = 1'b0;
            pad_oe  = 1'b0;
            for (int f = 0; f < NFUNC; f++) begin
                if (int'(sel) == f) begin
                    pad_out  = ch_out[f];
                    pad_oe   = ch_oe[f];
                    ch_in[f] = pad_in;
                end
            end
        end
    end
endmodule

// File: rtl/gpio_fnmux_port.sv
// Top of the GPIO port: register file, input synchroniser, per-pin routing
// and read-back multiplexer.
// Assumes the register port is read combinationally by word index.
module gpio_fnmux_port
    import gpio_fnmux_pkg::*;
#(
    parameter int NPINS   = 16,
    parameter int NFUNC   = 4,
    parameter int BUS_W   = 32,
    parameter int SYNC_ST = 2,
    localparam int SELW   = (NFUNC > 1) ? $clog2(NFUNC) : 1,
    localparam int CHW    = NPINS * NFUNC
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [REG_IDX_W-1:0] addr,
    input  logic [BUS_W-1:0]     wdata,
    output logic [BUS_W-1:0]     rdata,
    input  logic [NPINS-1:0]     pad_in,
    output logic [NPINS-1:0]     pad_out,
    output logic [NPINS-1:0]     pad_oe,
    input  logic [CHW-1:0]       fn_out,
    input  logic [CHW-1:0]       fn_oe,
    output logic [CHW-1:0]       fn_in
);
    logic [NPINS-1:0]      fnen_q;
    logic [NPINS*SELW-1:0] sel_q;
    logic [NPINS-1:0]      dout_q;
    logic [NPINS-1:0]      dir_q;
    logic [NPINS-1:0]      inen_q;
    logic [NPINS-1:0]      pad_sync;
    logic [NPINS-1:0]      data_view;

    gpio_fnmux_regs #(.NPINS(NPINS), .SELW(SELW), .BUS_W(BUS_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .addr   (addr),
        .wdata  (wdata),
        .fnen_q (fnen_q),
        .sel_q  (sel_q),
        .dout_q (dout_q),
        .dir_q  (dir_q),
        .inen_q (inen_q)
    );

    gpio_fnmux_sync #(.W(NPINS), .STAGES(SYNC_ST)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (pad_sync)
    );

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        gpio_fnmux_pin #(.NFUNC(NFUNC), .SELW(SELW)) u_pin (
            .fn_en    (fnen_q[p]),
            .sel      (sel_q[p*SELW +: SELW]),
            .gpio_out (dout_q[p]),
            .gpio_oe  (dir_q[p]),
            .pad_in   (pad_in[p]),
            .ch_out   (fn_out[p*NFUNC +: NFUNC]),
            .ch_oe    (fn_oe[p*NFUNC +: NFUNC]),
            .pad_out  (pad_out[p]),
            .pad_oe   (pad_oe[p]),
            .ch_in    (fn_in[p*NFUNC +: NFUNC])
        );
    end

    // Output pins show the latch, gated input pins the synchronised pad.
    always_comb data_view = (dir_q & dout_q) | (~dir_q & inen_q & pad_sync);

    // Read-back multiplexer by word index.
    always_comb begin
        case (reg_idx_e'(addr))
            RA_FNEN:   rdata = BUS_W'(fnen_q);
            RA_SEL:    rdata = BUS_W'(sel_q);
            RA_DATA,
            RA_DSET,
            RA_DCLR:   rdata = BUS_W'(data_view);
            RA_DIRSET,
            RA_DIRCLR: rdata = BUS_W'(dir_q);
            RA_INEN:   rdata = BUS_W'(inen_q);
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_fnmux_port_chk.sv
// Checker for gpio_fnmux_port: set/clear semantics, reset state and
// exclusive input routing. Attached with the bind below.
module gpio_fnmux_port_chk #(
    parameter int NPINS = 16,
    parameter int NFUNC = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   wr_en,
    input logic [2:0]             addr,
    input logic [NPINS-1:0]       wmask,
    input logic [NPINS-1:0]       fnen_q,
    input logic [NPINS-1:0]       dout_q,
    input logic [NPINS-1:0]       dir_q,
    input logic [NPINS-1:0]       inen_q,
    input logic [NPINS*NFUNC-1:0] fn_in
);
    // R1: reset clears all control state
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (fnen_q == '0 && dout_q == '0 && dir_q == '0 && inen_q == '0));

    // R5: set address raises masked bits, keeps the rest
    p_dset_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd3) |=>
        ((dout_q & $past(wmask)) == $past(wmask)) &&
        ((dout_q & ~$past(wmask)) == ($past(dout_q) & ~$past(wmask))));

    // R5: clear address drops masked bits, keeps the rest
    p_dclr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd4) |=>
        ((dout_q & $past(wmask)) == '0) &&
        ((dout_q & ~$past(wmask)) == ($past(dout_q) & ~$past(wmask))));

    // R6: direction set
    p_dirset_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd5) |=> ((dir_q & $past(wmask)) == $past(wmask)));

    // R6: direction clear
    p_dirclr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd6) |=> ((dir_q & $past(wmask)) == '0));

    for (genvar p = 0; p < NPINS; p++) begin : g_route
        // R4: at most one channel of a pin sees the pad
        p_fnin_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(fn_in[p*NFUNC +: NFUNC]));
        // R4: general-purpose pins feed no channel
        p_fnin_gpio_r4: assert property (@(posedge clk) disable iff (!rst_n)
            !fnen_q[p] |-> (fn_in[p*NFUNC +: NFUNC] == '0));
    end
endmodule

bind gpio_fnmux_port gpio_fnmux_port_chk #(.NPINS(NPINS), .NFUNC(NFUNC)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .addr   (addr),
    .wmask  (wdata[NPINS-1:0]),
    .fnen_q (fnen_q),
    .dout_q (dout_q),
    .dir_q  (dir_q),
    .inen_q (inen_q),
    .fn_in  (fn_in)
);

// File: tb/gpio_fnmux_port_tb.sv
module gpio_fnmux_port_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 16;
    localparam int CH = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [2:0]    addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic [NP-1:0] pad_in = '0;
    logic [NP-1:0] pad_out;
    logic [NP-1:0] pad_oe;
    logic [CH-1:0] fn_out = '0;
    logic [CH-1:0] fn_oe = '0;
    logic [CH-1:0] fn_in;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_fnmux_port u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .fn_out(fn_out), .fn_oe(fn_oe), .fn_in(fn_in)
    );

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        pad_in = 16'hFFFF;
        @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rd(3'(i), v);
            chk("R1 reg read", 64'(v), 64'h0);
        end
        chk("R1 pad_oe", 64'(pad_oe), 64'h0);
        chk("R1 fn_in", fn_in, 64'h0);
        pad_in = '0;
    endtask

    task automatic t_regs_readback();
        logic [31:0] v;
        wr(3'd1, 32'hE4E4_1B39);
        rd(3'd1, v); chk("R2 selector readback", 64'(v), 64'hE4E4_1B39);
        wr(3'd7, 32'h0000_A55A);
        rd(3'd7, v); chk("R2 input gate readback", 64'(v), 64'hA55A);
        wr(3'd7, 32'h0);
        wr(3'd1, 32'h0);
    endtask

    task automatic t_dir_data();
        logic [31:0] v;
        wr(3'd5, 32'h00FF);
        rd(3'd5, v); chk("R6 direction after set", 64'(v), 64'h00FF);
        wr(3'd6, 32'h000F);
        rd(3'd6, v); chk("R6 direction after clear", 64'(v), 64'h00F0);
        wr(3'd3, 32'h00A5);
        rd(3'd2, v); chk("R7 data read of outputs", 64'(v), 64'h00A0);
        @(negedge clk);
        chk("R3 pad_out follows latch", 64'(pad_out), 64'h00A5);
        chk("R3 pad_oe follows direction", 64'(pad_oe), 64'h00F0);
        wr(3'd4, 32'h0081);
        @(negedge clk);
        chk("R5 clear keeps unmasked bits", 64'(pad_out), 64'h0024);
        wr(3'd3, 32'h0300);
        @(negedge clk);
        chk("R5 set keeps unmasked bits", 64'(pad_out), 64'h0324);
        wr(3'd2, 32'h1234);
        @(negedge clk);
        chk("R10 whole latch write", 64'(pad_out), 64'h1234);
    endtask

    task automatic t_inputs();
        logic [31:0] v;
        wr(3'd6, 32'hFFFF);
        wr(3'd7, 32'h0);
        pad_in = 16'hBEEF;
        repeat (3) @(negedge clk);
        rd(3'd2, v); chk("R9 gate closed reads zero", 64'(v), 64'h0);
        wr(3'd7, 32'hFFFF);
        rd(3'd2, v); chk("R8 gated input", 64'(v), 64'hBEEF);
        @(negedge clk);
        pad_in = 16'h4321;
        @(negedge clk);
        rd(3'd2, v); chk("R8 not yet after one edge", 64'(v), 64'hBEEF);
        @(negedge clk);
        rd(3'd2, v); chk("R8 visible after two edges", 64'(v), 64'h4321);
        wr(3'd5, 32'hFF00);
        rd(3'd2, v); chk("R7 mixed outputs and inputs", 64'(v), 64'h1221);
        wr(3'd7, 32'h00F0);
        rd(3'd2, v); chk("R9 partial gate", 64'(v), 64'h1220);
    endtask

    task automatic t_periph();
        wr(3'd6, 32'hFFFF);
        wr(3'd5, 32'h8000);
        wr(3'd1, 32'h0000_000E);
        wr(3'd0, 32'h0003);
        fn_out = 64'h74;
        fn_oe  = 64'h84;
        pad_in = 16'h0003;
        @(negedge clk);
        chk("R4 peripheral pad_out", 64'(pad_out[1:0]), 64'h1);
        chk("R4 peripheral and gpio pad_oe", 64'(pad_oe), 64'h8003);
        chk("R4 input routed to owning channel", fn_in, 64'h84);
        pad_in = 16'h0;
        @(negedge clk);
        chk("R4 routed input follows pad", fn_in, 64'h0);
        wr(3'd0, 32'h0);
        pad_in = 16'h0003;
        @(negedge clk);
        chk("R4 gpio pins feed no channel", fn_in, 64'h0);
        chk("R3 released pins back to latch", 64'(pad_out[1:0]), 64'(2'b00));
    endtask

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_regs_readback();
        t_dir_data();
        t_inputs();
        t_periph();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule